// File: doc/BRIEF.md
# Coalescing Store Buffer

This block sits between a processor's store path and a write-issue port toward an external memory region. It has four entries. Each entry holds a doubleword-aligned address, one 64-bit data word, a mask of valid bytes and a memory-type code. While an entry stays open, later stores to the same doubleword with the same Normal type are merged into it byte by byte. This saves bus writes for sequences of narrow stores.

An entry closes, and so becomes eligible for write-out, for any of these reasons:
- all eight of its bytes have been written;
- its type is strict (Device or Strongly-ordered);
- it has waited a programmable number of cycles with no merge;
- a full drain is in progress.

Entries leave in allocation order through a valid/ready port, so store order is preserved downstream. A drain is started by a flush request, which covers explicit drains, cache maintenance and barriers, or by an accepted exclusive store to shared memory. A drain empties the whole buffer and reports completion with a one-cycle pulse.

Top module: `stbuf_coalesce`

## Requirements
- R1: The buffer holds at most four entries. `st_ready` is low when all four are valid and the presented store cannot merge into any of them.
- R2: A merge happens when a store has the same `st_addr[31:3]` as a valid open entry, the entry's type is Normal (`st_mtype` 0 = non-cacheable, 1 = write-through) and the types are identical. The merge overwrites only the bytes whose `st_strb` bit is set (bit i selects data bits 8i+7..8i) and ORs the strobes into the byte mask. Bytes never written read as zero, and `wr_addr[2:0]` is always zero.
- R3: An entry whose byte mask becomes all ones closes at once and is presented on the output port.
- R4: A store of strict type (`st_mtype` 2 = Device, 3 = Strongly-ordered) always takes a new entry, is never merged into, and is closed from allocation.
- R5: An open Normal entry closes after `timeout_cycles` consecutive clock edges with no merge. With `timeout_cycles` = N and an idle output, `wr_valid` rises on the Nth clock edge after the edge that accepted the store.
- R6: Entries are presented in allocation order. Only the oldest entry is presented, and only once it is closed or a drain is running. A presented entry holds its fields stable until `wr_ready` is high.
- R7: A one-cycle `flush_req`, or an accepted store with `st_excl` high, starts a drain. During a drain every entry is treated as closed and `st_ready` stays low until the buffer is empty.
- R8: `drain_done` is high for exactly one cycle, the cycle after the last entry of a drain is accepted downstream. For a flush of an empty buffer it is high in the cycle after the request.
- R9: When at least three entries are valid and any valid entry is of strict type, a store of strict type is held off (`st_ready` low) until that condition clears.
- R10: After reset the buffer is empty: `st_ready` is high, and `wr_valid` and `drain_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timeout_cycles | input | 16 | Idle cycles before an open entry closes |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request accepted this cycle when high with st_valid |
| st_addr | input | 32 | Store byte address |
| st_data | input | 64 | Store data, lane-aligned to the doubleword |
| st_strb | input | 8 | Byte enables |
| st_mtype | input | 2 | Memory type: 0 NC, 1 WT, 2 Device, 3 Strongly-ordered |
| st_excl | input | 1 | Exclusive store to shared memory; triggers a drain |
| flush_req | input | 1 | Drain request (explicit, maintenance, barrier) |
| wr_valid | output | 1 | Output entry valid |
| wr_ready | input | 1 | Downstream accepts output entry |
| wr_addr | output | 32 | Doubleword-aligned address of output entry |
| wr_data | output | 64 | Data of output entry |
| wr_strb | output | 8 | Byte mask of output entry |
| wr_mtype | output | 2 | Memory type of output entry |
| drain_done | output | 1 | One-cycle pulse when a drain completes |

## Verification
Three situations are hard to reach from the ports:
- The strict-type hold-off of R9 only shows when the buffer is nearly full, holds a strict entry, and sees another strict store. The bench stalls the output port, allocates a Device entry and two Normal entries, then offers a second Device store. It checks that the store is refused, and that it is taken in the cycle after the first Device entry leaves.
- Merging into a full buffer needs four open entries with the output stalled. The bench then offers first a non-matching store and then a matching one.
- For the exact timing of a timeout, the bench counts cycles from the accepting edge to the first `wr_valid`.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
  // Memory type codes; bit 1 set means a strict (non-mergeable) type.
  typedef enum logic [1:0] {
    MT_NORMAL_NC = 2'd0,
    MT_NORMAL_WT = 2'd1,
    MT_DEVICE    = 2'd2,
    MT_STRONG    = 2'd3
  } mtype_e;

  function automatic logic is_strict(input logic [1:0] mt);
    return mt[1];
  endfunction
endpackage

// File: rtl/stbuf_slot.sv
module stbuf_slot #(
  parameter int LW = 29,
  parameter int DW = 64,
  parameter int TW = 16,
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] limit,
  input  logic          alloc,
  input  logic          merge,
  input  logic          pop,
  input  logic [LW-1:0] in_line,
  input  logic [DW-1:0] in_data,
  input  logic [NB-1:0] in_strb,
  input  logic [1:0]    in_mtype,
  output logic          valid,
  output logic          closed,
  output logic [LW-1:0] line,
  output logic [DW-1:0] data,
  output logic [NB-1:0] mask,
  output logic [1:0]    mtype
);
  logic [TW-1:0] idle_cnt;
  logic [TW:0]   idle_nxt;

  assign idle_nxt = {1'b0, idle_cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= 1'b0;
      closed   <= 1'b0;
      idle_cnt <= '0;
      line     <= '0;
      data     <= '0;
      mask     <= '0;
      mtype    <= '0;
    end else if (pop) begin
      valid  <= 1'b0;
      closed <= 1'b0;
    end else if (alloc) begin
      valid    <= 1'b1;
      line     <= in_line;
      mtype    <= in_mtype;
      mask     <= in_strb;
      idle_cnt <= '0;
      closed   <= stbuf_pkg::is_strict(in_mtype) || (&in_strb) || (limit == '0);
      for (int b = 0; b < NB; b++)
        data[8*b +: 8] <= in_strb[b] ? in_data[8*b +: 8] : 8'h00;
    end else if (merge) begin
      mask     <= mask | in_strb;
      idle_cnt <= '0;
      closed   <= &(mask | in_strb);
      for (int b = 0; b < NB; b++)
        if (in_strb[b]) data[8*b +: 8] <= in_data[8*b +: 8];
    end else if (valid && !closed) begin
      idle_cnt <= idle_nxt[TW-1:0];
      if (idle_nxt >= {1'b0, limit}) closed <= 1'b1;
    end
  end
endmodule

// File: rtl/stbuf_match.sv
module stbuf_match #(
  parameter int DEPTH = 4,
  parameter int LW    = 29,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          s_valid  [DEPTH],
  input  logic          s_closed [DEPTH],
  input  logic [LW-1:0] s_line   [DEPTH],
  input  logic [1:0]    s_mtype  [DEPTH],
  input  logic [LW-1:0] in_line,
  input  logic [1:0]    in_mtype,
  output logic          hit_any,
  output logic [PW-1:0] hit_idx,
  output logic          strict_pend
);
  logic [DEPTH-1:0] hit;
  logic [DEPTH-1:0] strict_v;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = s_valid[i] && !s_closed[i] && !stbuf_pkg::is_strict(s_mtype[i])
                    && (s_mtype[i] == in_mtype) && (s_line[i] == in_line);
    assign strict_v[i] = s_valid[i] && stbuf_pkg::is_strict(s_mtype[i]);
  end

  assign hit_any     = |hit && !stbuf_pkg::is_strict(in_mtype);
  assign strict_pend = |strict_v;

  always_comb begin
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (hit[i]) hit_idx = PW'(i);
  end
endmodule

// File: rtl/stbuf_coalesce.sv
module stbuf_coalesce #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int TW    = 16,
  localparam int NB   = DW / 8,
  localparam int OFS  = $clog2(NB),
  localparam int LW   = AW - OFS,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] timeout_cycles,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [NB-1:0] st_strb,
  input  logic [1:0]    st_mtype,
  input  logic          st_excl,
  input  logic          flush_req,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [NB-1:0] wr_strb,
  output logic [1:0]    wr_mtype,
  output logic          drain_done
);
  logic          s_valid  [DEPTH];
  logic          s_closed [DEPTH];
  logic [LW-1:0] s_line   [DEPTH];
  logic [DW-1:0] s_data   [DEPTH];
  logic [NB-1:0] s_mask   [DEPTH];
  logic [1:0]    s_mtype  [DEPTH];

  logic [PW-1:0] head, tail, hit_idx;
  logic [CW-1:0] count, count_nxt;
  logic          hit_any, strict_pend, drain_mode, drain_pend;
  logic          acc, do_alloc, do_merge, pop, gate_strict, full;

  stbuf_match #(.DEPTH(DEPTH), .LW(LW)) match_i (
    .s_valid(s_valid), .s_closed(s_closed), .s_line(s_line), .s_mtype(s_mtype),
    .in_line(st_addr[AW-1:OFS]), .in_mtype(st_mtype),
    .hit_any(hit_any), .hit_idx(hit_idx), .strict_pend(strict_pend)
  );

  assign full        = (count == CW'(DEPTH));
  assign gate_strict = stbuf_pkg::is_strict(st_mtype) && (count >= CW'(DEPTH - 1)) && strict_pend;
  assign st_ready    = !drain_mode && (hit_any || !full) && !gate_strict;
  assign acc         = st_valid && st_ready;
  assign do_merge    = acc && hit_any;
  assign do_alloc    = acc && !hit_any;

  assign wr_valid = s_valid[head] && (s_closed[head] || drain_mode);
  assign pop      = wr_valid && wr_ready;
  assign wr_addr  = {s_line[head], {OFS{1'b0}}};
  assign wr_data  = s_data[head];
  assign wr_strb  = s_mask[head];
  assign wr_mtype = s_mtype[head];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    stbuf_slot #(.LW(LW), .DW(DW), .TW(TW)) slot_i (
      .clk(clk), .rst(rst), .limit(timeout_cycles),
      .alloc(do_alloc && (tail == PW'(i))),
      .merge(do_merge && (hit_idx == PW'(i))),
      .pop(pop && (head == PW'(i))),
      .in_line(st_addr[AW-1:OFS]), .in_data(st_data), .in_strb(st_strb),
      .in_mtype(st_mtype),
      .valid(s_valid[i]), .closed(s_closed[i]), .line(s_line[i]),
      .data(s_data[i]), .mask(s_mask[i]), .mtype(s_mtype[i])
    );
  end

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign count_nxt  = count + CW'(do_alloc) - CW'(pop);
  assign drain_pend = drain_mode || flush_req || (acc && st_excl);

  always_ff @(posedge clk) begin
    if (rst) begin
      head       <= '0;
      tail       <= '0;
      count      <= '0;
      drain_mode <= 1'b0;
      drain_done <= 1'b0;
    end else begin
      if (do_alloc) tail <= ptr_inc(tail);
      if (pop)      head <= ptr_inc(head);
      count      <= count_nxt;
      drain_mode <= drain_pend && (count_nxt != '0);
      drain_done <= drain_pend && (count_nxt == '0);
    end
  end
endmodule

// File: rtl/stbuf_coalesce_chk.sv
module stbuf_coalesce_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 64,
  localparam int NB   = DW / 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          st_valid,
  input logic          st_ready,
  input logic [1:0]    st_mtype,
  input logic          flush_req,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [NB-1:0] wr_strb,
  input logic          drain_done,
  input logic [CW-1:0] count,
  input logic          hit_any,
  input logic          strict_pend
);
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_ready && count == CW'(DEPTH)) |-> hit_any);

  assert_strict_alloc_R4: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_ready && st_mtype[1]) |=>
      (count == $past(count) + CW'(1) - CW'($past(wr_valid && wr_ready))));

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=>
      (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_strb)));

  assert_drain_block_R7: assert property (@(posedge clk) disable iff (rst)
    (flush_req && wr_valid && !wr_ready) |=> !st_ready);

  assert_done_empty_R8: assert property (@(posedge clk) disable iff (rst)
    drain_done |-> (!wr_valid && count == '0));

  assert_strict_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_ready && st_mtype[1] && count >= CW'(DEPTH - 1)) |-> !strict_pend);
endmodule

bind stbuf_coalesce stbuf_coalesce_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
  .st_mtype(st_mtype), .flush_req(flush_req), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
  .drain_done(drain_done), .count(count), .hit_any(hit_any),
  .strict_pend(strict_pend)
);

// File: tb/stbuf_coalesce_tb_top.sv
`timescale 1ns/1ps
module stbuf_coalesce_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] timeout_cycles = 16'd200;
  logic        st_valid = 1'b0, st_ready;
  logic [31:0] st_addr = '0;
  logic [63:0] st_data = '0;
  logic [7:0]  st_strb = '0;
  logic [1:0]  st_mtype = '0;
  logic        st_excl = 1'b0, flush_req = 1'b0;
  logic        wr_valid, wr_ready = 1'b1;
  logic [31:0] wr_addr;
  logic [63:0] wr_data;
  logic [7:0]  wr_strb;
  logic [1:0]  wr_mtype;
  logic        drain_done;

  int n_tests = 0;
  int n_fail  = 0;
  logic [105:0] exp_q[$];

  always #2 clk = ~clk;

  stbuf_coalesce dut_i (
    .clk(clk), .rst(rst), .timeout_cycles(timeout_cycles),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .st_strb(st_strb), .st_mtype(st_mtype),
    .st_excl(st_excl), .flush_req(flush_req), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_strb(wr_strb), .wr_mtype(wr_mtype), .drain_done(drain_done)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [63:0] mrg(input logic [63:0] base, input logic [63:0] d,
                                      input logic [7:0] s);
    logic [63:0] r = base;
    for (int b = 0; b < 8; b++) if (s[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  task automatic expect_wr(input logic [31:0] a, input logic [63:0] d,
                           input logic [7:0] s, input logic [1:0] mt);
    exp_q.push_back({a, d, s, mt});
  endtask

  // Scoreboard monitor: compares each accepted output entry (R2, R6).
  always @(posedge clk) begin
    if (!rst && wr_valid && wr_ready) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R6 unexpected output actual=%0h expected=none", wr_addr);
      end else begin
        logic [105:0] e;
        e = exp_q.pop_front();
        if (e != {wr_addr, wr_data, wr_strb, wr_mtype}) begin
          n_fail++;
          $display("FAIL R2/R6 output actual=%h expected=%h",
                   {wr_addr, wr_data, wr_strb, wr_mtype}, e);
        end
      end
    end
  end

  task automatic put(input logic [31:0] a, input logic [63:0] d, input logic [7:0] s,
                     input logic [1:0] mt, input logic ex);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d; st_strb = s; st_mtype = mt; st_excl = ex;
    @(posedge clk);
    while (!st_ready) @(posedge clk);
    @(negedge clk);
    st_valid = 1'b0; st_excl = 1'b0;
  endtask

  task automatic wait_empty(input string req);
    for (int i = 0; i < 100 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic flush(input int n);
    int k = 0;
    bit first = 1'b1;
    @(negedge clk);
    flush_req = 1'b1;
    while (k < n) begin
      if (!first) chk(!st_ready, "R7 ready low in drain", st_ready, 0);
      if (wr_valid && wr_ready) k++;
      if (k < n) begin
        @(negedge clk);
        flush_req = 1'b0;
        first = 1'b0;
      end
    end
    chk(!drain_done, "R8 early", drain_done, 0);
    @(negedge clk);
    flush_req = 1'b0;
    chk(drain_done, "R8 pulse", drain_done, 1);
    @(negedge clk);
    chk(!drain_done, "R8 single cycle", drain_done, 0);
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(st_ready && !wr_valid && !drain_done, "R10 reset state",
        {st_ready, wr_valid, drain_done}, 3'b100);

    // R2, R3: two halves merge into one full entry that leaves at once.
    expect_wr(32'h100, mrg(mrg(64'h0, 64'h1111_2222_3333_4444, 8'h0F),
                           64'h5555_6666_7777_8888, 8'hF0), 8'hFF, 2'd0);
    put(32'h100, 64'h1111_2222_3333_4444, 8'h0F, 2'd0, 1'b0);
    put(32'h104, 64'h5555_6666_7777_8888, 8'hF0, 2'd0, 1'b0);
    wait_empty("R3 full entry emitted");

    // R2: different Normal types to one doubleword do not merge.
    expect_wr(32'h140, mrg(64'h0, 64'hA1A2, 8'h01), 8'h01, 2'd0);
    expect_wr(32'h140, mrg(64'h0, 64'hB1B2, 8'h02), 8'h02, 2'd1);
    put(32'h140, 64'hA1A2, 8'h01, 2'd0, 1'b0);
    put(32'h140, 64'hB1B2, 8'h02, 2'd1, 1'b0);
    flush(2);

    // R5: timeout of 6 edges; first seen at the 7th falling edge after the accepting edge.
    timeout_cycles = 16'd6;
    expect_wr(32'h200, mrg(64'h0, 64'hC3, 8'h01), 8'h01, 2'd1);
    put(32'h203, 64'hC3, 8'h01, 2'd1, 1'b0);
    begin
      int n = 1;
      while (!wr_valid && n < 50) begin @(negedge clk); n++; end
      chk(n == 7, "R5 timeout latency", n, 7);
    end
    wait_empty("R5 timed-out entry emitted");
    timeout_cycles = 16'd200;

    // R4: Device stores to one doubleword stay separate and leave at once.
    expect_wr(32'h300, 64'h11, 8'h01, 2'd2);
    expect_wr(32'h300, 64'h2200, 8'h02, 2'd2);
    put(32'h300, 64'h11, 8'h01, 2'd2, 1'b0);
    put(32'h300, 64'h2200, 8'h02, 2'd2, 1'b0);
    wait_empty("R4 strict emitted unmerged");

    // R6: an open Normal head blocks a closed Device entry behind it; R7 flush drains both in order.
    expect_wr(32'h380, 64'h5A, 8'h01, 2'd0);
    expect_wr(32'h3C0, 64'h6B, 8'h01, 2'd3);
    put(32'h380, 64'h5A, 8'h01, 2'd0, 1'b0);
    put(32'h3C0, 64'h6B, 8'h01, 2'd3, 1'b0);
    @(negedge clk);
    chk(!wr_valid, "R6 open head blocks", wr_valid, 0);
    flush(2);

    // R1: full buffer refuses a new line but still merges into an open entry.
    wr_ready = 1'b0;
    expect_wr(32'h1000, 64'h01, 8'h01, 2'd0);
    expect_wr(32'h1008, mrg(64'h02, 64'h0300, 8'h02), 8'h03, 2'd0);
    expect_wr(32'h1010, 64'h04, 8'h01, 2'd0);
    expect_wr(32'h1018, 64'h05, 8'h01, 2'd0);
    put(32'h1000, 64'h01, 8'h01, 2'd0, 1'b0);
    put(32'h1008, 64'h02, 8'h01, 2'd0, 1'b0);
    put(32'h1010, 64'h04, 8'h01, 2'd0, 1'b0);
    put(32'h1018, 64'h05, 8'h01, 2'd0, 1'b0);
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'h1020; st_data = 64'h9; st_strb = 8'h01; st_mtype = 2'd0;
    @(negedge clk);
    chk(!st_ready, "R1 full refuses new line", st_ready, 0);
    st_addr = 32'h1009; st_data = 64'h0300; st_strb = 8'h02;
    @(negedge clk);
    chk(st_ready, "R1 full still merges", st_ready, 1);
    @(negedge clk);
    st_valid = 1'b0;
    wr_ready = 1'b1;
    flush(4);

    // R9: strict store held off while nearly full with a strict entry pending.
    wr_ready = 1'b0;
    expect_wr(32'h500, 64'h77, 8'h01, 2'd2);
    expect_wr(32'h600, 64'h88, 8'h01, 2'd0);
    expect_wr(32'h700, 64'h99, 8'h01, 2'd0);
    expect_wr(32'h580, 64'hAA, 8'h01, 2'd2);
    put(32'h500, 64'h77, 8'h01, 2'd2, 1'b0);
    put(32'h600, 64'h88, 8'h01, 2'd0, 1'b0);
    put(32'h700, 64'h99, 8'h01, 2'd0, 1'b0);
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'h580; st_data = 64'hAA; st_strb = 8'h01; st_mtype = 2'd2;
    @(negedge clk);
    chk(!st_ready, "R9 strict store held", st_ready, 0);
    wr_ready = 1'b1;
    @(negedge clk);
    chk(st_ready, "R9 released after strict leaves", st_ready, 1);
    @(negedge clk);
    st_valid = 1'b0;
    flush(3);

    // R7: an exclusive store starts a drain by itself.
    expect_wr(32'h800, 64'h12, 8'h01, 2'd0);
    expect_wr(32'h900, 64'h3456, 8'h0F, 2'd0);
    put(32'h800, 64'h12, 8'h01, 2'd0, 1'b0);
    put(32'h900, 64'h3456, 8'h0F, 2'd0, 1'b1);
    chk(!st_ready, "R7 exclusive drain blocks input", st_ready, 0);
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 50 && !seen; i++) begin
        @(negedge clk);
        seen = drain_done;
      end
      chk(seen, "R8 exclusive drain done", seen, 1);
    end
    wait_empty("R7 exclusive drain emitted");

    // R8: flush of an empty buffer.
    flush(0);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R6 scoreboard empty", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule